// File: doc/BRIEF.md
# Segment LCD display memory

This block is the display data store of a four-common multiplexed segment LCD controller. It holds 32 four-bit words. Word n drives segment n, and bit k of each word selects that segment during common k. A host writes the words through a command port. An address counter, which can be preset, points at the word to write and steps forward by itself after each write, so a display image can be streamed in without sending addresses again.

The host can give three useful commands. An address-set loads the counter. An 8-bit data write fills two neighbouring words in one transfer. A 4-bit rewrite changes a single word. A scan port takes the number of the common now being driven and returns the 32 segment bits for that common at once, one bit per address. The read-out is combinational from the stored words.

The host port follows valid/ready rules. The block never applies back-pressure: `host_ready` is held high, so every cycle with `host_valid` high is an accepted transfer. A transfer with `host_valid` low has no effect. After reset the word contents are undefined until the host writes them.

Top module: `seg_lcd_dmem`

## Requirements
- R1: The memory holds 32 words of 4 bits. `scan_seg[n]` equals bit `scan_com` of word n, for n from 0 to 31 and `scan_com` from 0 to 3.
- R2: An accepted transfer with `host_op` = 2'd0 (address set) loads `host_data[4:0]` into the address counter and writes no word.
- R3: An accepted transfer with `host_op` = 2'd2 (4-bit rewrite) stores `host_data[3:0]` at the current address, then adds 1 to the address.
- R4: An accepted transfer with `host_op` = 2'd1 (8-bit write) stores `host_data[3:0]` at address n and `host_data[7:4]` at address n+1 mod 32, then adds 2 to the address.
- R5: The address wraps from 31 to 0. An 8-bit write at 31 puts its upper nibble at word 0 and leaves the counter at 1. An 8-bit write at 30 leaves it at 0.
- R6: The counter keeps its value and no word changes when `host_valid` is low or when `host_op` = 2'd3, which is a no-operation code.
- R7: A synchronous active-high `rst` clears the address counter to 0.
- R8: In the cycle a word is written, `scan_seg` still shows the old contents. The new contents show from the next cycle on.
- R9: `host_ready` is high in every cycle, reset included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host command present |
| host_ready | output | 1 | Always high; the block accepts every command |
| host_op | input | 2 | 0 address set, 1 8-bit write, 2 4-bit rewrite, 3 no-op |
| host_data | input | 8 | Address in [4:0] for op 0; data for ops 1 and 2 |
| scan_com | input | 2 | Index of the common now being driven |
| scan_seg | output | 32 | Segment bits for that common, bit n from word n |

## Verification
The bench goes after the wrap of the counter. It aims 8-bit writes at 30 and 31 and rewrites at 31. A design that wraps wrongly would write the upper nibble at address 32 (which is lost), or leave the counter at a value past 31. The bench also checks that the two write steps are not swapped: a design that advanced by 1 after an 8-bit write would have the next write overwrite the upper nibble. It checks that op 3 and idle cycles leave the counter alone, so a design that steps on them would place the next rewrite at the wrong address. Finally, it compares the scan output in the cycle of the write. A design with a write-through bypass would show the new data one cycle early, and a registered read-out would show it one cycle late.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_WR8 = 2'd1,
    OP_WR4 = 2'd2,
    OP_NOP = 2'd3
  } host_op_e;
endpackage

// File: rtl/seg_addr_ctr.sv
module seg_addr_ctr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr
);
  import seg_lcd_pkg::*;

  logic [ADDR_W-1:0] addr_nx;

  always_comb begin
    addr_nx = addr;
    if (accept) begin
      unique case (op)
        OP_SET:  addr_nx = load_val;
        OP_WR8:  addr_nx = addr + ADDR_W'(2);
        OP_WR4:  addr_nx = addr + ADDR_W'(1);
        default: addr_nx = addr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else     addr <= addr_nx;
  end

  // R7
  reset_clears_chk: assert property (@(posedge clk) rst |=> addr == '0);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SET) |=> addr == $past(load_val));
  // R4
  step_two_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_WR8) |=> addr == ADDR_W'($past(addr) + ADDR_W'(2)));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_WR4) |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept || op == OP_NOP) |=> $stable(addr));
endmodule

// File: rtl/seg_nibble_ram.sv
module seg_nibble_ram #(
  parameter int ADDR_W = 5,
  parameter int NIB    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we_lo,
  input  logic                           we_hi,
  input  logic [ADDR_W-1:0]              addr_lo,
  input  logic [ADDR_W-1:0]              addr_hi,
  input  logic [NIB-1:0]                 d_lo,
  input  logic [NIB-1:0]                 d_hi,
  output logic [(1<<ADDR_W)*NIB-1:0]     mem_flat
);
  localparam int WORDS = 1 << ADDR_W;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [NIB-1:0] word_q;
    always_ff @(posedge clk) begin
      if (we_lo && addr_lo == ADDR_W'(i))      word_q <= d_lo;
      else if (we_hi && addr_hi == ADDR_W'(i)) word_q <= d_hi;
    end
    assign mem_flat[i*NIB +: NIB] = word_q;
  end

  // R3
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> mem_flat[$past(addr_lo)*NIB +: NIB] == $past(d_lo));
  // R4
  high_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_hi |=> mem_flat[$past(addr_hi)*NIB +: NIB] == $past(d_hi));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_lo && !we_hi) |=> $stable(mem_flat));
endmodule

// File: rtl/seg_scan_mux.sv
module seg_scan_mux #(
  parameter int WORDS = 32,
  parameter int NIB   = 4,
  localparam int COM_W = $clog2(NIB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WORDS*NIB-1:0]   mem_flat,
  input  logic [COM_W-1:0]       com,
  output logic [WORDS-1:0]       seg
);
  for (genvar n = 0; n < WORDS; n++) begin : g_seg
    logic [NIB-1:0] w;
    assign w      = mem_flat[n*NIB +: NIB];
    assign seg[n] = w[com];
  end

  // R1
  seg_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(mem_flat) && $stable(com)) |-> $stable(seg));
  // R1
  seg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    seg[0] == mem_flat[com]);
endmodule

// File: rtl/seg_lcd_dmem.sv
module seg_lcd_dmem #(
  parameter int ADDR_W = 5,
  parameter int NIB    = 4,
  localparam int WORDS = 1 << ADDR_W,
  localparam int COM_W = $clog2(NIB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [1:0]        host_op,
  input  logic [2*NIB-1:0]  host_data,
  input  logic [COM_W-1:0]  scan_com,
  output logic [WORDS-1:0]  scan_seg
);
  import seg_lcd_pkg::*;

  logic              accept;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_next_word;
  logic              we_lo, we_hi;
  logic [WORDS*NIB-1:0] mem_flat;

  assign host_ready     = 1'b1;
  assign accept         = host_valid && host_ready;
  assign addr_next_word = addr + ADDR_W'(1);
  assign we_lo          = accept && (host_op == OP_WR8 || host_op == OP_WR4);
  assign we_hi          = accept && (host_op == OP_WR8);

  seg_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .op       (host_op),
    .load_val (host_data[ADDR_W-1:0]),
    .addr     (addr)
  );

  seg_nibble_ram #(.ADDR_W(ADDR_W), .NIB(NIB)) u_ram (
    .clk      (clk),
    .rst      (rst),
    .we_lo    (we_lo),
    .we_hi    (we_hi),
    .addr_lo  (addr),
    .addr_hi  (addr_next_word),
    .d_lo     (host_data[NIB-1:0]),
    .d_hi     (host_data[2*NIB-1:NIB]),
    .mem_flat (mem_flat)
  );

  seg_scan_mux #(.WORDS(WORDS), .NIB(NIB)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .mem_flat (mem_flat),
    .com      (scan_com),
    .seg      (scan_seg)
  );

  // R9
  ready_high_chk: assert property (@(posedge clk) host_ready);
  // R5
  wrap_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (we_hi && addr == ADDR_W'(WORDS-1)) |=> mem_flat[NIB-1:0] == $past(host_data[2*NIB-1:NIB]));
endmodule

// File: tb/seg_lcd_dmem_tb.sv
module seg_lcd_dmem_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [1:0]  host_op = 2'd3;
  logic [7:0]  host_data = 8'h00;
  logic [1:0]  scan_com = 2'd0;
  logic [31:0] scan_seg;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R7";

  // reference model
  int m_addr = 0;
  int m_mem  [32];
  bit m_known[32];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_lcd_dmem u_dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_op(host_op), .host_data(host_data), .scan_com(scan_com), .scan_seg(scan_seg)
  );

  initial foreach (m_known[i]) begin m_known[i] = 0; m_mem[i] = 0; end

  always @(posedge clk) begin
    cycles++;
    if (rst) m_addr = 0;
    else if (host_valid) begin
      case (host_op)
        2'd0: m_addr = host_data[4:0];
        2'd1: begin
          m_mem[m_addr] = host_data[3:0];          m_known[m_addr] = 1;
          m_mem[(m_addr+1)%32] = host_data[7:4];   m_known[(m_addr+1)%32] = 1;
          m_addr = (m_addr + 2) % 32;
        end
        2'd2: begin
          m_mem[m_addr] = host_data[3:0]; m_known[m_addr] = 1;
          m_addr = (m_addr + 1) % 32;
        end
        default: ;
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic [31:0] exp_v, mask;
    if (!done) begin
      for (int n = 0; n < 32; n++) begin
        mask[n]  = m_known[n];
        exp_v[n] = m_known[n] ? m_mem[n][scan_com] : 1'b0;
      end
      total++;
      if ((scan_seg & mask) !== exp_v) begin
        bad++;
        $display("FAIL %s scan com=%0d actual=%h expected=%h mask=%h",
                 phase, scan_com, scan_seg & mask, exp_v, mask);
      end
      total++;
      if (host_ready !== 1'b1) begin  // R9
        bad++;
        $display("FAIL R9 host_ready actual=%b expected=1", host_ready);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input bit v, input logic [1:0] op, input logic [7:0] d, input logic [1:0] com);
    @(negedge clk); #1;
    host_valid = v; host_op = op; host_data = d; scan_com = com;
  endtask

  task automatic sweep_com();
    for (int c = 0; c < 4; c++) step(0, 2'd3, 8'h00, c[1:0]);
  endtask

  initial begin
    repeat (3) step(0, 2'd3, 8'h00, 2'd0);
    rst = 0;
    // R7: rewrite straight after reset lands at word 0
    phase = "R7";
    step(1, 2'd2, 8'h0A, 2'd1);
    sweep_com();
    // R4: fill whole memory with 8-bit writes, wrapping back to 0
    phase = "R4";
    step(1, 2'd0, 8'h00, 2'd0);
    for (int i = 0; i < 16; i++) step(1, 2'd1, 8'(i*37 + 5), 2'(i));
    sweep_com();
    // R1: distinct pattern per common
    phase = "R1";
    for (int i = 0; i < 32; i++) step(1, 2'd2, 8'(i ^ (i >> 2)), 2'(i));
    sweep_com();
    // R2: address set then rewrite
    phase = "R2";
    step(1, 2'd0, 8'h13, 2'd2);
    step(1, 2'd2, 8'hF6, 2'd1);
    step(1, 2'd0, 8'hE7, 2'd3);   // upper bits ignored, loads 7
    step(1, 2'd2, 8'h09, 2'd0);
    sweep_com();
    // R3: consecutive rewrites
    phase = "R3";
    for (int i = 0; i < 6; i++) step(1, 2'd2, 8'(15 - i), 2'(i));
    sweep_com();
    // R5: wrap cases
    phase = "R5";
    step(1, 2'd0, 8'h1F, 2'd0);
    step(1, 2'd1, 8'hC3, 2'd0);   // 31 gets 3, 0 gets C, addr 1
    step(1, 2'd2, 8'h05, 2'd2);   // lands at 1
    step(1, 2'd0, 8'h1E, 2'd3);
    step(1, 2'd1, 8'h96, 2'd1);   // 30,31; addr 0
    step(1, 2'd2, 8'h0E, 2'd2);   // lands at 0
    step(1, 2'd0, 8'h1F, 2'd0);
    step(1, 2'd2, 8'h01, 2'd0);   // 31, addr 0
    step(1, 2'd2, 8'h08, 2'd3);   // lands at 0
    sweep_com();
    // R6: idle and op 3 change nothing
    phase = "R6";
    step(1, 2'd0, 8'h0C, 2'd0);
    step(0, 2'd1, 8'hFF, 2'd1);
    step(1, 2'd3, 8'hFF, 2'd2);
    step(0, 2'd2, 8'hFF, 2'd3);
    step(1, 2'd2, 8'h06, 2'd0);   // must land at 12
    sweep_com();
    // R8: write while scanning the same common
    phase = "R8";
    step(1, 2'd0, 8'h04, 2'd1);
    step(1, 2'd2, 8'h0D, 2'd1);
    step(1, 2'd1, 8'h72, 2'd1);
    step(0, 2'd3, 8'h00, 2'd1);
    // R7: reset mid-run
    phase = "R7";
    step(1, 2'd0, 8'h11, 2'd0);
    rst = 1;
    step(0, 2'd3, 8'h00, 2'd0);
    rst = 0;
    step(1, 2'd2, 8'h03, 2'd0);
    sweep_com();
    // R1: mixed traffic
    phase = "R1";
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 8'($urandom), 2'($urandom_range(0, 3)));
    sweep_com();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule